// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits on the write side of a two-bank flash command interface. It sees every bus write as a single-cycle beat with address and data. From that stream it recognises the multi-write erase command protocol. The protocol is an unlock pair, an erase setup code, a second unlock pair, and then a confirm that picks either one block or a whole bank. The decoder turns the protocol into one-cycle request pulses for the erase controller. It also keeps a bitmap of the blocks selected for erasure, which the controller reads.

After a block confirm, the decoder enters a collection window. While that window is open, more block confirms are taken without any unlock writes, and each one adds its block to the bitmap. The window closes when the controller reports that erasure has started. The decoder then accepts suspend, and once suspended it accepts resume. Malformed sequences produce an abort pulse and return the decoder to idle (read-array). A queued block that lies in the other bank also produces an abort pulse and returns the decoder to idle.

Write beats arrive as a valid-only stream. There is no back-pressure: the decoder takes every beat in the cycle where `wr_valid` is high, so no ready signal exists. The erase controller inputs are plain level controls. They are acted on only in cycles without a write beat. All outputs are registered, so every pulse appears in the cycle after the write that caused it.

Top module: `flash_erase_seq_dec`

## Requirements
- R1: After reset, all request pulses are low, `blk_map` is zero, and the decoder is idle.
- R2: The six-write sequence starts the block-erase form of the protocol. The writes are AAh at offset 555h, 55h at offset 2AAh, 80h at offset 555h, AAh at 555h, 55h at 2AAh, and then 30h. Only offset bits [10:0] are compared, and the address layout is {bank, block, offset}. The last write pulses `blk_erase_req` with `req_bank`/`req_blk` taken from its address, and sets bit {bank, block} of `blk_map`.
- R3: While the collection window is open, a 30h write whose bank matches the first block pulses `blk_queue_req` and sets that block's bit in `blk_map`. No unlock writes are needed.
- R4: While the collection window is open, a 30h write to the other bank pulses `abort_req`, clears `blk_map`, and returns to idle.
- R5: Any wrong unlock write, a setup code other than 80h, or a sixth write that is neither 30h nor 10h pulses `abort_req` and returns to idle. A following lone 30h write then produces no pulse.
- R6: A sixth write of 10h pulses `bank_erase_req` and sets every `blk_map` bit of the addressed bank.
- R7: A B0h write at any address pulses `suspend_req` only while a block erase is executing. A B0h write during idle or during a bank erase produces no pulse.
- R8: While suspended, a 30h write to the bank being erased pulses `resume_req`. A 30h write to the other bank, or a 30h write during an unsuspended erase, produces no pulse.
- R9: An F0h write before erasure begins pulses `reset_req`, clears `blk_map` and returns to idle. This applies during the unlock writes and during the collection window. An F0h write during an executing erase produces no pulse and leaves `blk_map` unchanged.
- R10: `erase_start` closes the collection window. `erase_done` during an executing erase clears `blk_map` and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present this cycle |
| wr_addr | input | BANK_BITS+BLK_W+OFS_W (15) | Write address {bank, block, offset} |
| wr_data | input | 8 | Write data (command code) |
| erase_start | input | 1 | Controller: collection timeout expired, erasure running |
| erase_done | input | 1 | Controller: erasure finished |
| blk_erase_req | output | 1 | First block confirm accepted |
| blk_queue_req | output | 1 | Extra block queued |
| bank_erase_req | output | 1 | Bank erase confirmed |
| suspend_req | output | 1 | Suspend accepted |
| resume_req | output | 1 | Resume accepted |
| reset_req | output | 1 | Reset to read-array accepted |
| abort_req | output | 1 | Sequence aborted to read-array |
| req_bank | output | 1 | Bank of the latest block or bank request |
| req_blk | output | BLK_W (3) | Block of the latest block request |
| blk_map | output | 2**(BLK_W+1) (16) | Selected-block bitmap, index {bank, block} |

## Verification
Several properties are checked by the assertions on every cycle. At most one request pulse is high at a time. An abort always leaves the bitmap empty. A bank erase always leaves exactly one bank's worth of bits set. A queued block's bit is always present. Suspend and resume pulses appear only from the executing and suspended states respectively. Other behaviour can only be shown by the bench's scenarios. This covers the ordering of the six-write protocol, the rejection of specific malformed writes, the accumulation of randomly chosen queued blocks, and the fact that writes in the wrong phase are ignored.

// File: rtl/fesd_pkg.sv
package fesd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_SETUP, ST_SU1, ST_SU2,
    ST_COLLECT, ST_ERASE, ST_SUSP, ST_BANK_BUSY
  } fesd_state_e;

  localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
  localparam logic [7:0]  CMD_UNLK_B = 8'h55;
  localparam logic [7:0]  CMD_SETUP  = 8'h80;
  localparam logic [7:0]  CMD_BLK    = 8'h30;
  localparam logic [7:0]  CMD_BANK   = 8'h10;
  localparam logic [7:0]  CMD_SUSP   = 8'hB0;
  localparam logic [7:0]  CMD_RST    = 8'hF0;
  localparam logic [10:0] ADR_UNLK_A = 11'h555;
  localparam logic [10:0] ADR_UNLK_B = 11'h2AA;

  typedef struct packed {
    logic unlk_a;
    logic unlk_b;
    logic setup;
    logic blk;
    logic bank;
    logic susp;
    logic rst;
  } fesd_cls_t;
endpackage

// File: rtl/fesd_cycle_match.sv
module fesd_cycle_match
  import fesd_pkg::*;
#(
  parameter int BLK_W = 3,
  parameter int OFS_W = 11,
  localparam int AW = 1 + BLK_W + OFS_W
) (
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       data,
  output fesd_cls_t        cls,
  output logic             bank,
  output logic [BLK_W-1:0] blk
);
  logic [10:0] ofs;
  assign ofs  = addr[10:0];
  assign bank = addr[AW-1];
  assign blk  = addr[OFS_W +: BLK_W];

  always_comb begin
    cls.unlk_a = (data == CMD_UNLK_A) && (ofs == ADR_UNLK_A);
    cls.unlk_b = (data == CMD_UNLK_B) && (ofs == ADR_UNLK_B);
    cls.setup  = (data == CMD_SETUP)  && (ofs == ADR_UNLK_A);
    cls.blk    = (data == CMD_BLK);
    cls.bank   = (data == CMD_BANK);
    cls.susp   = (data == CMD_SUSP);
    cls.rst    = (data == CMD_RST);
  end
endmodule

// File: rtl/fesd_blk_map.sv
module fesd_blk_map #(
  parameter int BLK_W = 3,
  localparam int NBLK = 1 << BLK_W,
  localparam int NTOT = 2 * NBLK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_en,
  input  logic             set_bank,
  input  logic [BLK_W-1:0] set_blk,
  input  logic             fill_en,
  output logic [NTOT-1:0]  map
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar k = 0; k < NBLK; k++) begin : g_blk
      logic hit;
      assign hit = (set_bank == 1'(b)) && (set_blk == BLK_W'(k));
      always_ff @(posedge clk) begin
        if (!rst_n || clr)            map[b*NBLK+k] <= 1'b0;
        else if (fill_en && set_bank == 1'(b)) map[b*NBLK+k] <= 1'b1;
        else if (set_en && hit)       map[b*NBLK+k] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_erase_seq_dec.sv
module flash_erase_seq_dec
  import fesd_pkg::*;
#(
  parameter int BLK_W = 3,
  parameter int OFS_W = 11,
  localparam int AW   = 1 + BLK_W + OFS_W,
  localparam int NBLK = 1 << BLK_W,
  localparam int NTOT = 2 * NBLK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             erase_start,
  input  logic             erase_done,
  output logic             blk_erase_req,
  output logic             blk_queue_req,
  output logic             bank_erase_req,
  output logic             suspend_req,
  output logic             resume_req,
  output logic             reset_req,
  output logic             abort_req,
  output logic             req_bank,
  output logic [BLK_W-1:0] req_blk,
  output logic [NTOT-1:0]  blk_map
);
  fesd_state_e state, nxt;
  fesd_cls_t   cls;
  logic        w_bank, er_bank;
  logic [BLK_W-1:0] w_blk;
  logic [6:0]  pls_n;
  logic        m_clr, m_set, m_fill, bank_ld;

  fesd_cycle_match #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_match (
    .addr(wr_addr), .data(wr_data), .cls(cls), .bank(w_bank), .blk(w_blk)
  );

  fesd_blk_map #(.BLK_W(BLK_W)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(m_clr), .set_en(m_set),
    .set_bank(w_bank), .set_blk(w_blk), .fill_en(m_fill), .map(blk_map)
  );

  // pls_n bits: 6 blk, 5 queue, 4 bank, 3 susp, 2 resume, 1 reset, 0 abort
  always_comb begin
    nxt = state; pls_n = '0;
    m_clr = 1'b0; m_set = 1'b0; m_fill = 1'b0; bank_ld = 1'b0;
    if (wr_valid) begin
      unique case (state)
        ST_IDLE: begin
          if (cls.unlk_a)   nxt = ST_U1;
          else if (cls.rst) pls_n[1] = 1'b1;
        end
        ST_U1, ST_U2, ST_SETUP, ST_SU1: begin
          if (cls.rst) begin
            pls_n[1] = 1'b1; nxt = ST_IDLE;
          end else if (state == ST_U1 && cls.unlk_b)    nxt = ST_U2;
          else if (state == ST_U2 && cls.setup)         nxt = ST_SETUP;
          else if (state == ST_SETUP && cls.unlk_a)     nxt = ST_SU1;
          else if (state == ST_SU1 && cls.unlk_b)       nxt = ST_SU2;
          else begin
            pls_n[0] = 1'b1; nxt = ST_IDLE;
          end
        end
        ST_SU2: begin
          if (cls.rst) begin
            pls_n[1] = 1'b1; nxt = ST_IDLE;
          end else if (cls.blk) begin
            pls_n[6] = 1'b1; m_set = 1'b1; bank_ld = 1'b1; nxt = ST_COLLECT;
          end else if (cls.bank) begin
            pls_n[4] = 1'b1; m_fill = 1'b1; bank_ld = 1'b1; nxt = ST_BANK_BUSY;
          end else begin
            pls_n[0] = 1'b1; nxt = ST_IDLE;
          end
        end
        ST_COLLECT: begin
          if (cls.rst) begin
            pls_n[1] = 1'b1; m_clr = 1'b1; nxt = ST_IDLE;
          end else if (cls.blk && w_bank == er_bank) begin
            pls_n[5] = 1'b1; m_set = 1'b1;
          end else begin
            pls_n[0] = 1'b1; m_clr = 1'b1; nxt = ST_IDLE;
          end
        end
        ST_ERASE: if (cls.susp) begin
          pls_n[3] = 1'b1; nxt = ST_SUSP;
        end
        ST_SUSP: if (cls.blk && w_bank == er_bank) begin
          pls_n[2] = 1'b1; nxt = ST_ERASE;
        end
        default: ;
      endcase
    end else begin
      if (state == ST_COLLECT && erase_start) nxt = ST_ERASE;
      if ((state == ST_ERASE || state == ST_BANK_BUSY) && erase_done) begin
        m_clr = 1'b1; nxt = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      er_bank <= 1'b0;
      {blk_erase_req, blk_queue_req, bank_erase_req, suspend_req,
       resume_req, reset_req, abort_req} <= '0;
      req_bank <= 1'b0;
      req_blk  <= '0;
    end else begin
      state <= nxt;
      {blk_erase_req, blk_queue_req, bank_erase_req, suspend_req,
       resume_req, reset_req, abort_req} <= pls_n;
      if (bank_ld) er_bank <= w_bank;
      if (pls_n[6] || pls_n[5] || pls_n[4]) begin
        req_bank <= w_bank;
        req_blk  <= w_blk;
      end
    end
  end

  p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({blk_erase_req, blk_queue_req, bank_erase_req, suspend_req,
              resume_req, reset_req, abort_req}));
  p_blk_marked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_erase_req |-> $countones(blk_map) == 1);
  p_queue_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_queue_req |-> blk_map[{req_bank, req_blk}]);
  p_abort_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> blk_map == '0);
  p_bank_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_erase_req |-> $countones(blk_map) == NBLK);
  p_susp_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> $past(state) == ST_ERASE);
  p_resume_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(state) == ST_SUSP);
endmodule

// File: tb/tb_flash_erase_seq_dec.sv
module tb_flash_erase_seq_dec;
  localparam int BLK_W = 3;
  localparam int OFS_W = 11;
  localparam int AW = 1 + BLK_W + OFS_W;
  localparam int NTOT = 2 << BLK_W;
  localparam logic [6:0] PB = 7'b1000000, PQ = 7'b0100000, PK = 7'b0010000,
                         PS = 7'b0001000, PR = 7'b0000100, PX = 7'b0000010,
                         PA = 7'b0000001, P0 = 7'b0000000;

  logic clk = 1'b0, rst_n = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic erase_start = 1'b0, erase_done = 1'b0;
  logic blk_erase_req, blk_queue_req, bank_erase_req, suspend_req;
  logic resume_req, reset_req, abort_req, req_bank;
  logic [BLK_W-1:0] req_blk;
  logic [NTOT-1:0] blk_map;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_erase_seq_dec #(.BLK_W(BLK_W), .OFS_W(OFS_W)) dut (.*);

  function automatic logic [AW-1:0] adr(input logic b, input logic [BLK_W-1:0] k,
                                        input logic [10:0] o);
    return {b, k, o};
  endfunction

  function automatic logic [6:0] pls();
    return {blk_erase_req, blk_queue_req, bank_erase_req, suspend_req,
            resume_req, reset_req, abort_req};
  endfunction

  function automatic logic [NTOT-1:0] bit_of(input logic b, input logic [BLK_W-1:0] k);
    return NTOT'(1) << {b, k};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic ctl(input bit st, input bit dn);
    @(negedge clk); erase_start = st; erase_done = dn;
    @(negedge clk); erase_start = 1'b0; erase_done = 1'b0;
  endtask

  task automatic prefix(input string tag);
    wr(adr(0, 0, 11'h555), 8'hAA); chk({tag, " unlock1 quiet"}, 32'(pls()), 32'(P0));
    wr(adr(0, 0, 11'h2AA), 8'h55);
    wr(adr(0, 0, 11'h555), 8'h80);
    wr(adr(0, 0, 11'h555), 8'hAA);
    wr(adr(0, 0, 11'h2AA), 8'h55); chk({tag, " unlock4 quiet"}, 32'(pls()), 32'(P0));
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [NTOT-1:0] exp_map;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulses", 32'(pls()), 32'(P0));
    chk("R1 map", 32'(blk_map), 0);

    // R2 block erase
    prefix("R2");
    wr(adr(0, 3, 11'h017), 8'h30);
    chk("R2 pulse", 32'(pls()), 32'(PB));
    chk("R2 blk", 32'({req_bank, req_blk}), 32'({1'b0, 3'd3}));
    chk("R2 map", 32'(blk_map), 32'(bit_of(0, 3)));
    // R3 queue
    wr(adr(0, 5, 11'h100), 8'h30);
    chk("R3 pulse", 32'(pls()), 32'(PQ));
    chk("R3 map", 32'(blk_map), 32'(bit_of(0, 3) | bit_of(0, 5)));
    // R4 other bank
    wr(adr(1, 2, 11'h0), 8'h30);
    chk("R4 pulse", 32'(pls()), 32'(PA));
    chk("R4 map", 32'(blk_map), 0);

    // R5 malformed
    wr(adr(0, 0, 11'h555), 8'hAA); wr(adr(0, 0, 11'h2AA), 8'h55);
    wr(adr(0, 0, 11'h555), 8'h80); wr(adr(0, 0, 11'h555), 8'hAA);
    wr(adr(0, 0, 11'h2AA), 8'h12);
    chk("R5 bad unlock", 32'(pls()), 32'(PA));
    wr(adr(0, 1, 11'h0), 8'h30);
    chk("R5 idle after abort", 32'(pls()), 32'(P0));
    wr(adr(0, 0, 11'h555), 8'hAA); wr(adr(0, 0, 11'h2AA), 8'h55);
    wr(adr(0, 0, 11'h555), 8'h90);
    chk("R5 bad setup", 32'(pls()), 32'(PA));
    prefix("R5");
    wr(adr(0, 0, 11'h0), 8'h77);
    chk("R5 bad confirm", 32'(pls()), 32'(PA));

    // R6 bank erase, R7 no suspend there, R10 done
    prefix("R6");
    wr(adr(1, 4, 11'h3), 8'h10);
    chk("R6 pulse", 32'(pls()), 32'(PK));
    chk("R6 map", 32'(blk_map), 32'hFF00);
    wr(adr(1, 0, 11'h0), 8'hB0);
    chk("R7 no suspend in bank erase", 32'(pls()), 32'(P0));
    ctl(0, 1);
    chk("R10 done clears map", 32'(blk_map), 0);
    wr(adr(0, 0, 11'h0), 8'hB0);
    chk("R7 no suspend idle", 32'(pls()), 32'(P0));

    // R9 reset in collect window
    prefix("R9");
    wr(adr(1, 6, 11'h0), 8'h30);
    wr(adr(0, 0, 11'h0), 8'hF0);
    chk("R9 reset pulse", 32'(pls()), 32'(PX));
    chk("R9 reset map", 32'(blk_map), 0);
    wr(adr(0, 0, 11'h555), 8'hAA);
    wr(adr(0, 0, 11'h0), 8'hF0);
    chk("R9 reset in unlock", 32'(pls()), 32'(PX));

    // R7 R8 R9 R10 executing erase
    prefix("R8");
    wr(adr(0, 1, 11'h0), 8'h30);
    ctl(1, 0);
    wr(adr(0, 0, 11'h0), 8'hF0);
    chk("R9 ignored while erasing", 32'(pls()), 32'(P0));
    chk("R9 map kept", 32'(blk_map), 32'(bit_of(0, 1)));
    wr(adr(0, 2, 11'h0), 8'h30);
    chk("R8 no resume unsuspended", 32'(pls()), 32'(P0));
    chk("R10 no queue after start", 32'(blk_map), 32'(bit_of(0, 1)));
    wr(adr(1, 7, 11'h44), 8'hB0);
    chk("R7 suspend", 32'(pls()), 32'(PS));
    wr(adr(1, 1, 11'h0), 8'h30);
    chk("R8 other bank ignored", 32'(pls()), 32'(P0));
    wr(adr(0, 6, 11'h0), 8'h30);
    chk("R8 resume", 32'(pls()), 32'(PR));
    ctl(0, 1);
    chk("R10 map cleared", 32'(blk_map), 0);

    // random: garbage in idle, then random block queues
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (d == 8'hAA || d == 8'hF0) d = 8'h00;
      wr(AW'($urandom), d);
      chk("R5 idle garbage quiet", 32'(pls()), 32'(P0));
    end
    for (int i = 0; i < 30; i++) begin
      logic b;
      logic [BLK_W-1:0] k;
      int nq;
      b = 1'($urandom); k = BLK_W'($urandom); nq = $urandom_range(0, 4);
      prefix("R2 rnd");
      wr(adr(b, k, 11'($urandom)), 8'h30);
      exp_map = bit_of(b, k);
      chk("R2 rnd pulse", 32'(pls()), 32'(PB));
      chk("R2 rnd map", 32'(blk_map), 32'(exp_map));
      for (int q = 0; q < nq; q++) begin
        k = BLK_W'($urandom);
        wr(adr(b, k, 11'($urandom)), 8'h30);
        exp_map |= bit_of(b, k);
        chk("R3 rnd queue", 32'(pls()), 32'(PQ));
        chk("R3 rnd map", 32'(blk_map), 32'(exp_map));
      end
      if (i % 3 == 0) begin
        wr(adr(~b, k, 11'h0), 8'h30);
        chk("R4 rnd abort", 32'(pls()), 32'(PA));
        chk("R4 rnd map", 32'(blk_map), 0);
      end else begin
        ctl(1, 0);
        ctl(0, 1);
        chk("R10 rnd done", 32'(blk_map), 0);
      end
    end

    finished = 1'b1;
    summary();
  end
endmodule